// File: doc/BRIEF.md
# Power-of-Two Square-Wave Output Divider

This block turns a master oscillator tick into a square-wave output whose period is a power-of-two multiple of the master period, from 1 up to 128. The ratio comes from a 4-bit select code. That code arrives as raw samples from a voltage-to-code converter, each marked by a one-cycle strobe. A run filter qualifies the samples before any of them can reach the divider. The top bit of the accepted code also chooses what the output does while it is disabled: it is either driven low or released to high impedance. The output is modelled as a data bit plus a drive-enable bit, so the high-impedance state is visible in simulation.

The master oscillator is seen as a one-cycle tick on the fast system clock, at twice the master frequency. The output spends N ticks high and N ticks low, where N is the decoded ratio. Pulling the enable low removes the output at once, without waiting for a clock edge. When the enable returns, the output restarts only at a rising edge of the internal divider, so no shortened pulse appears. A new ratio waits for the end of the current period. The output stays off after reset until a code has been accepted.

Top module: `pow2_out_divider`

## Requirements
- R1: While reset is asserted, out_data is 0, out_drive is 1 and code_ok is 0.
- R2: A sample is taken only in a cycle with code_smp_vld high. A code is accepted once 4 samples in a row carry that same value, with no differing sample between them. code_ok rises when the first code is accepted and then stays high until reset.
- R3: The ratio exponent E is decoded from the accepted code C. For C in 0..7, E = C[2:0]. For C in 8..15, E = 7 − C[2:0]. The ratio is N = 2^E, so code 3 gives 8, code 4 gives 16, codes 7 and 8 give 128, and codes 0 and 15 give 1.
- R4: While enabled with a valid code, out_data is high for exactly N master ticks and then low for exactly N master ticks, and it changes only on the clock edge that follows a tick.
- R5: While code_ok is 0, out_data stays 0, whatever the enable does.
- R6: When out_en is 0, out_data is 0 without waiting for a clock edge. In the same condition, out_drive is 1 if bit 3 of the accepted code is 0 (driven low) and 0 if that bit is 1 (high impedance).
- R7: After out_en rises, out_data stays 0 until a rising edge of the internal divider. The first high phase then lasts the full N ticks.
- R8: A newly accepted code changes the ratio only at a falling edge of out_data (the end of a period). Every high or low phase lasts either the old ratio or the new one, never any other length.
- R9: While out_en is 1, out_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mtick | input | 1 | One-cycle master oscillator tick, at twice the master rate |
| code_smp | input | 4 | Raw select-code sample from the converter |
| code_smp_vld | input | 1 | Strobe marking a new sample on code_smp |
| out_en | input | 1 | Output enable; low disables the output at once |
| code_ok | output | 1 | A filtered code has been accepted |
| out_data | output | 1 | Divided output level |
| out_drive | output | 1 | Output driver enable; 0 means high impedance |

## Verification
The divider is checked across the code space with codes 0, 3, 4, 7, 8, 9, 12 and 15. Pairs from the two halves of the code range land on the same ratio, so these codes separate a mirrored decode from a straight one. The two ends of the range, ratios 1 and 128, check the counter limits.

For the filter, a run of three samples is sent, then a run broken by a differing value, and then a full run of four. These show whether acceptance counts a true run or only counts strobes.

Disable is applied in the middle of a high phase, once with each value of the mode bit. The output is observed before the next clock edge, which separates an asynchronous cut-off from a registered one. After re-enable, the first pulse is measured. While a ratio change is in progress, every phase is measured, which catches a ratio that switches partway through a phase.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

  // Default widths shared by the divider blocks.
  localparam int DEF_CODE_W  = 4;
  localparam int DEF_RUN_LEN = 4;

  // What the output does while disabled.
  typedef enum logic {
    OFF_DRIVE_LOW = 1'b0,
    OFF_FLOAT     = 1'b1
  } off_mode_e;

endpackage

// File: rtl/odiv_code_filter.sv
module odiv_code_filter #(
  parameter int CODE_W  = 4,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp,
  output logic [CODE_W-1:0] acc_code,
  output logic              acc_ok
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(RUN_LEN);

  logic [CODE_W-1:0] cand_q, cand_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [CODE_W-1:0] acc_q, acc_d;
  logic              ok_q, ok_d;

  // Next state: track the candidate and its run; promote it when the run completes.
  always_comb begin
    cand_d = cand_q;
    run_d  = run_q;
    acc_d  = acc_q;
    ok_d   = ok_q;
    if (smp_vld) begin
      if (smp == cand_q) begin
        if (run_q != RUN_DONE) begin
          run_d = run_q + 1'b1;
        end
      end else begin
        cand_d = smp;
        run_d  = RUN_W'(1);
      end
      if (run_d == RUN_DONE) begin
        acc_d = cand_d;
        ok_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      run_q  <= '0;
      acc_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      cand_q <= cand_d;
      run_q  <= run_d;
      acc_q  <= acc_d;
      ok_q   <= ok_d;
    end
  end

  assign acc_code = acc_q;
  assign acc_ok   = ok_q;

endmodule

// File: rtl/odiv_ratio_decode.sv
module odiv_ratio_decode
  import odiv_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter bit MIRROR = 1'b1
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-2:0] ratio_exp,
  output off_mode_e         off_mode
);

  localparam int EXP_W = CODE_W - 1;

  // The top code bit selects the disabled-output mode.
  assign off_mode = off_mode_e'(code[CODE_W-1]);

  generate
    if (MIRROR) begin : g_mirror
      // Upper half of the code range counts back down the ratios.
      assign ratio_exp = code[CODE_W-1] ? ~code[EXP_W-1:0] : code[EXP_W-1:0];
    end else begin : g_straight
      assign ratio_exp = code[EXP_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/odiv_phase_gen.sv
module odiv_phase_gen #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [EXP_W-1:0] new_exp,
  output logic             phase,
  output logic             rise_evt
);

  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam logic [EXP_W-1:0] TOP_EXP = EXP_W'(MAX_EXP);

  logic             live_q, live_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [CNT_W-1:0] span;
  logic             at_last;

  // Last count of a half period is 2^exp - 1.
  always_comb begin
    span    = {CNT_W{1'b1}} >> (TOP_EXP - exp_q);
    at_last = (cnt_q == span);
  end

  always_comb begin
    live_d = run;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    exp_d  = exp_q;
    if (!live_q) begin
      // Idle: hold at the start of a low phase and track the code.
      cnt_d = '0;
      ph_d  = 1'b0;
      exp_d = new_exp;
    end else if (tick) begin
      if (at_last) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
        if (ph_q) begin
          exp_d = new_exp;          // end of period: ratio update point
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      exp_q  <= '0;
    end else begin
      live_q <= live_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      exp_q  <= exp_d;
    end
  end

  assign phase    = ph_q;
  assign rise_evt = live_q & tick & at_last & ~ph_q;

endmodule

// File: rtl/odiv_out_stage.sv
module odiv_out_stage
  import odiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      ok,
  input  logic      phase,
  input  logic      rise_evt,
  input  off_mode_e off_mode,
  output logic      out_data,
  output logic      out_drive
);

  logic gate_q, gate_d;

  // The gate opens only on a divider rising edge, so the first pulse is whole.
  always_comb begin
    gate_d = gate_q;
    if (!en || !ok) begin
      gate_d = 1'b0;
    end else if (rise_evt) begin
      gate_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  // The enable also acts combinationally, so disable needs no clock edge.
  assign out_data  = en & gate_q & phase;
  assign out_drive = en | (off_mode == OFF_DRIVE_LOW);

endmodule

// File: rtl/pow2_out_divider.sv
module pow2_out_divider
  import odiv_pkg::*;
#(
  parameter int CODE_W  = DEF_CODE_W,
  parameter int RUN_LEN = DEF_RUN_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mtick,
  input  logic [CODE_W-1:0] code_smp,
  input  logic              code_smp_vld,
  input  logic              out_en,
  output logic              code_ok,
  output logic              out_data,
  output logic              out_drive
);

  localparam int EXP_W = CODE_W - 1;

  logic [CODE_W-1:0] acc_code;
  logic              acc_ok;
  logic [EXP_W-1:0]  ratio_exp;
  off_mode_e         off_mode;
  logic              phase;
  logic              rise_evt;

  odiv_code_filter #(
    .CODE_W (CODE_W),
    .RUN_LEN(RUN_LEN)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (code_smp_vld),
    .smp     (code_smp),
    .acc_code(acc_code),
    .acc_ok  (acc_ok)
  );

  odiv_ratio_decode #(
    .CODE_W(CODE_W),
    .MIRROR(1'b1)
  ) u_decode (
    .code     (acc_code),
    .ratio_exp(ratio_exp),
    .off_mode (off_mode)
  );

  odiv_phase_gen #(
    .EXP_W(EXP_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (mtick),
    .run     (acc_ok),
    .new_exp (ratio_exp),
    .phase   (phase),
    .rise_evt(rise_evt)
  );

  odiv_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (out_en),
    .ok       (acc_ok),
    .phase    (phase),
    .rise_evt (rise_evt),
    .off_mode (off_mode),
    .out_data (out_data),
    .out_drive(out_drive)
  );

  assign code_ok = acc_ok;

endmodule

// File: rtl/pow2_out_divider_chk.sv
module pow2_out_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic mtick,
  input logic code_smp_vld,
  input logic out_en,
  input logic code_ok,
  input logic out_data,
  input logic out_drive
);

  // R5
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |-> !out_data);

  // R2
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok |=> code_ok);

  // R2
  accept_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_ok) |-> $past(code_smp_vld));

  // R4
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && $past(out_en) && !$stable(out_data)) |-> $past(mtick));

  // R7
  reenable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> !out_data);

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !out_data);

  // R9
  enabled_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> out_drive);

endmodule

bind pow2_out_divider pow2_out_divider_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mtick       (mtick),
  .code_smp_vld(code_smp_vld),
  .out_en      (out_en),
  .code_ok     (code_ok),
  .out_data    (out_data),
  .out_drive   (out_drive)
);

// File: tb/pow2_out_divider_test.sv
module pow2_out_divider_test;

  logic       clk;
  logic       rst_n;
  logic       mtick;
  logic       tick_on;
  logic [3:0] code_smp;
  logic       code_smp_vld;
  logic       out_en;
  logic       code_ok;
  logic       out_data;
  logic       out_drive;

  int  checks;
  int  errors;
  bit  done;

  pow2_out_divider uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mtick       (mtick),
    .code_smp    (code_smp),
    .code_smp_vld(code_smp_vld),
    .out_en      (out_en),
    .code_ok     (code_ok),
    .out_data    (out_data),
    .out_drive   (out_drive)
  );

  // 250 MHz clock
  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Master tick every second clock cycle.
  always @(negedge clk) begin
    if (!tick_on) mtick <= 1'b0;
    else          mtick <= ~mtick;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic feed(input logic [3:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      code_smp     = c;
      code_smp_vld = 1'b1;
      @(negedge clk);
      code_smp_vld = 1'b0;
    end
  endtask

  task automatic wait_edge(input bit rising, output bit ok);
    bit prev;
    prev = out_data;
    ok   = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (rising ? (!prev && out_data) : (prev && !out_data)) begin
        ok = 1'b1;
        break;
      end
      prev = out_data;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    bit ok;
    hi = 0;
    lo = 0;
    wait_edge(1'b0, ok);
    if (!ok) return;
    wait_edge(1'b1, ok);
    if (!ok) return;
    hi = 1;
    @(negedge clk);
    while (out_data && hi < 5000) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!out_data && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_data == 1'b0, "R1", "out_data in reset", out_data, 0);
    chk(out_drive == 1'b1, "R1", "out_drive in reset", out_drive, 1);
    chk(code_ok == 1'b0, "R1", "code_ok in reset", code_ok, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_startup;
    int highs;
    highs   = 0;
    out_en  = 1'b1;
    tick_on = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (out_data) highs++;
    end
    chk(highs == 0, "R5", "high samples before code", highs, 0);
    chk(code_ok == 1'b0, "R5", "code_ok without samples", code_ok, 0);
  endtask

  task automatic t_filter;
    int hi, lo;
    feed(4'd5, 3);
    repeat (2) @(negedge clk);
    chk(code_ok == 1'b0, "R2", "code_ok after 3 samples", code_ok, 0);
    feed(4'd6, 1);
    feed(4'd5, 3);
    repeat (2) @(negedge clk);
    chk(code_ok == 1'b0, "R2", "code_ok after broken run", code_ok, 0);
    feed(4'd5, 1);
    @(negedge clk);
    chk(code_ok == 1'b1, "R2", "code_ok after 4 in a row", code_ok, 1);
    measure(hi, lo);
    chk(hi == 64, "R3", "code 5 high cycles", hi, 64);
  endtask

  task automatic t_ratio(input logic [3:0] c, input int n);
    int hi, lo;
    feed(c, 4);
    measure(hi, lo);
    chk(hi == 2 * n, "R3", $sformatf("code %0d high cycles", c), hi, 2 * n);
    chk(lo == 2 * n, "R4", $sformatf("code %0d low cycles", c), lo, 2 * n);
    chk(out_drive == 1'b1, "R9", "drive while enabled", out_drive, 1);
  endtask

  task automatic t_disable;
    bit ok;
    int highs;
    highs = 0;
    wait_edge(1'b1, ok);
    @(negedge clk);
    out_en = 1'b0;
    #1;
    chk(out_data == 1'b0, "R6", "data right after disable", out_data, 0);
    chk(out_drive == 1'b1, "R6", "drive-low mode drive", out_drive, 1);
    repeat (50) begin
      @(negedge clk);
      if (out_data) highs++;
    end
    chk(highs == 0, "R6", "highs while disabled", highs, 0);
  endtask

  task automatic t_reenable;
    bit ok;
    int hi;
    @(negedge clk);
    out_en = 1'b1;
    #1;
    chk(out_data == 1'b0, "R7", "data right after enable", out_data, 0);
    wait_edge(1'b1, ok);
    hi = 1;
    @(negedge clk);
    while (out_data && hi < 5000) begin hi++; @(negedge clk); end
    chk(hi == 8, "R7", "first pulse after enable", hi, 8);
  endtask

  task automatic t_change;
    int lens[12];
    fork
      feed(4'd1, 4);
      begin
        bit ok;
        bit lvl;
        int run;
        int idx;
        wait_edge(1'b1, ok);
        lvl = 1'b1;
        run = 1;
        idx = 0;
        while (idx < 12) begin
          @(negedge clk);
          if (out_data == lvl) run++;
          else begin
            lens[idx] = run;
            idx++;
            lvl = out_data;
            run = 1;
          end
        end
      end
    join
    for (int i = 0; i < 12; i++) begin
      chk(lens[i] == 4 || lens[i] == 8, "R8",
          $sformatf("phase %0d length", i), lens[i], 4);
    end
    chk(lens[11] == 4, "R8", "phase length after change", lens[11], 4);
  endtask

  task automatic t_float;
    bit ok;
    feed(4'd10, 4);
    wait_edge(1'b0, ok);
    wait_edge(1'b1, ok);
    @(negedge clk);
    out_en = 1'b0;
    #1;
    chk(out_data == 1'b0, "R6", "float mode data", out_data, 0);
    chk(out_drive == 1'b0, "R6", "float mode drive", out_drive, 0);
    @(negedge clk);
    out_en = 1'b1;
    #1;
    chk(out_drive == 1'b1, "R9", "drive after enable", out_drive, 1);
  endtask

  initial begin
    checks       = 0;
    errors       = 0;
    done         = 1'b0;
    rst_n        = 1'b0;
    tick_on      = 1'b0;
    code_smp     = '0;
    code_smp_vld = 1'b0;
    out_en       = 1'b0;
    t_reset();
    t_startup();
    t_filter();
    t_ratio(4'd0, 1);
    t_ratio(4'd3, 8);
    t_ratio(4'd4, 16);
    t_ratio(4'd7, 128);
    t_ratio(4'd8, 128);
    t_ratio(4'd9, 64);
    t_ratio(4'd12, 8);
    t_ratio(4'd15, 1);
    t_ratio(4'd2, 4);
    t_disable();
    t_reenable();
    t_change();
    t_float();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule